// File: doc/BRIEF.md
# Left-Justified Stereo Serial Audio Port

This block is a serial audio port that runs as bit-clock and word-select master. It sends and receives two-sample frames in left-justified form. Every word-select period holds two slots of `HALF_BITS` bit clocks each, one per level of word-select. Each slot carries one sample, most significant bit first. The first bit of a sample sits in the first bit clock after the word-select edge, with no one-bit delay. Any slot bits beyond the programmed word length are padding. `LANES` serial data lanes run side by side in each direction, all framed by the same word-select.

The transmit side takes a whole frame (both samples for every lane) through a valid/ready interface into a one-frame holding register. That register is moved into the shifters at the start of each frame. If no frame is waiting at that point, the previous frame is sent again and an underrun is flagged. The receive side collects both samples of every lane and presents them as one frame on a valid/ready interface. If a frame completes while the previous one has not yet been taken, the new frame overwrites it and an overrun is flagged. The word length and the choice of the word-select edge that opens a frame are sampled once per frame, so both samples of a frame always share one length.

Top module: `lj_stereo_port`

## Requirements
- R1: `sck` toggles on every `clk` cycle, and one frame spans 2*`HALF_BITS` `sck` periods. `ws` changes only together with a falling edge of `sck`. During the first slot `ws` is low when `cfg_first_fall`=1 and high when it is 0. During the second slot `ws` takes the opposite level.
- R2: Within each slot, the sample is driven MSB first and begins in the slot's first bit clock. Slot positions at or beyond the word length are driven 0. `sd_out` changes only on a falling edge of `sck`.
- R3: The effective word length is `cfg_word_len` clamped to the range 8..min(32,`HALF_BITS`). It is sampled at the start of each frame and applies to both slots of that frame, in both directions.
- R4: The receiver samples `sd_in` on rising `sck` edges. It delivers each frame's two samples right-aligned, with upper bits zero. In the 2*32-bit field of each lane, the upper word is the first slot and the lower word the second slot. Lane l uses bits [64l+63:64l].
- R5: All lanes shift at the same time under the shared `ws`, and each lane carries its own independent sample pair.
- R6: A lane with `tx_lane_en` low drives `sd_out` low. A lane with `rx_lane_en` low is delivered as all zeros.
- R7: `tx_ready` is high exactly when the holding register is empty. A frame is accepted on a clock where `tx_valid` and `tx_ready` are both high. A held frame is loaded at the next frame start.
- R8: At a frame start with an empty holding register, the previous frame is sent again and `tx_underrun` pulses for exactly the one following cycle.
- R9: `rx_valid` rises when a frame completes and stays high until `rx_ready` is seen. A frame that completes while `rx_valid` is high and `rx_ready` is low replaces the data and pulses `rx_overrun` for one cycle.
- R10: Under synchronous reset, `sd_out`, `rx_valid`, `tx_underrun` and `rx_overrun` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word_len | input | 6 | Requested sample length in bits |
| cfg_first_fall | input | 1 | 1: first slot opens on a falling ws edge; 0: on a rising edge |
| tx_lane_en | input | LANES | Per-lane transmit enable |
| rx_lane_en | input | LANES | Per-lane receive enable |
| tx_valid | input | 1 | Transmit frame offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | LANES*64 | Transmit frame, per-lane {first, second} |
| tx_underrun | output | 1 | Pulse: frame start with no new frame |
| rx_valid | output | 1 | Received frame available |
| rx_ready | input | 1 | Consumer takes the received frame |
| rx_data | output | LANES*64 | Received frame, per-lane {first, second} |
| rx_overrun | output | 1 | Pulse: unread frame overwritten |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd_out | output | LANES | Serial transmit data |
| sd_in | input | LANES | Serial receive data |

## Verification
Two events can fall on one clock edge: a transmit underrun at a frame start, and the acceptance of a new frame into the holding register that has just been found empty. The bench provokes this by offering nothing for a whole frame. `tx_ready` is then high at the boundary, and the bench offers a frame on that same edge. Correct behaviour means three things: the underrun pulse appears, the old frame is sent again (looped back and compared), and the frame offered on that edge shows up in the following frame rather than being lost or loaded early. A stalled consumer likewise places an overrun on the same edge as a delivery. The bench expects the overwritten data and the pulse together.

// File: rtl/lj_pkg.sv
package lj_pkg;

    parameter int MAX_W = 32;
    parameter int MIN_W = 8;
    localparam int WL_W = 6;

    typedef logic [MAX_W-1:0] word_t;

    typedef struct packed {
        word_t first;
        word_t second;
    } pair_t;

    function automatic logic [WL_W-1:0] clamp_len(input logic [WL_W-1:0] req, input int limit);
        int v;
        v = int'(req);
        if (v < MIN_W) v = MIN_W;
        if (v > limit) v = limit;
        return WL_W'(v);
    endfunction

    function automatic logic pick_bit(input word_t w, input int pos, input int len);
        if (pos < len) return w[len-1-pos];
        return 1'b0;
    endfunction

endpackage

// File: rtl/lj_frame_gen.sv
module lj_frame_gen
    import lj_pkg::*;
#(
    parameter int HALF_BITS = 32,
    localparam int IDX_W = $clog2(2*HALF_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_first_fall,
    output logic             sck_o,
    output logic             ws_o,
    output logic             fall_ev,
    output logic             rise_ev,
    output logic             frame_start,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] nxt_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(2*HALF_BITS-1);
    localparam logic [IDX_W-1:0] HALF = IDX_W'(HALF_BITS);

    logic             sck_q, ws_q, lvl_q, lvl;
    logic [IDX_W-1:0] idx_q, nxt;

    assign fall_ev     = sck_q;
    assign rise_ev     = ~sck_q;
    assign nxt         = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    assign frame_start = fall_ev && (nxt == '0);
    assign lvl         = frame_start ? ~cfg_first_fall : lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b1;
            idx_q <= LAST;
            ws_q  <= 1'b0;
            lvl_q <= 1'b1;
        end else begin
            sck_q <= ~sck_q;
            if (fall_ev) begin
                idx_q <= nxt;
                ws_q  <= (nxt < HALF) ? lvl : ~lvl;
            end
            if (frame_start) lvl_q <= ~cfg_first_fall;
        end
    end

    assign sck_o = sck_q;
    assign ws_o  = ws_q;
    assign idx_o = idx_q;
    assign nxt_o = nxt;

    a_r1_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_q) |-> $fell(sck_q));

endmodule

// File: rtl/lj_tx_lane.sv
module lj_tx_lane
    import lj_pkg::*;
#(
    parameter int HALF_BITS = 32,
    localparam int IDX_W = $clog2(2*HALF_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fall_ev,
    input  logic [IDX_W-1:0] nxt,
    input  logic [WL_W-1:0]  len,
    input  pair_t            sample,
    output logic             sd_o
);
    localparam logic [IDX_W-1:0] HALF = IDX_W'(HALF_BITS);

    logic             second_slot, bit_nxt, sd_q;
    logic [IDX_W-1:0] pos;

    assign second_slot = (nxt >= HALF);
    assign pos         = second_slot ? nxt - HALF : nxt;
    assign bit_nxt     = pick_bit(second_slot ? sample.second : sample.first,
                                  int'(pos), int'(len));

    always_ff @(posedge clk) begin
        if (rst)          sd_q <= 1'b0;
        else if (fall_ev) sd_q <= en & bit_nxt;
    end

    assign sd_o = sd_q;

    a_r2_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_q) |-> $past(fall_ev));
    a_r6_off_low: assert property (@(posedge clk) disable iff (rst)
        (fall_ev && !en) |=> (sd_q == 1'b0));

endmodule

// File: rtl/lj_rx_lane.sv
module lj_rx_lane
    import lj_pkg::*;
#(
    parameter int HALF_BITS = 32,
    localparam int IDX_W = $clog2(2*HALF_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rise_ev,
    input  logic [IDX_W-1:0] idx,
    input  logic [WL_W-1:0]  len,
    input  logic             sd_i,
    output pair_t            pair_o
);
    localparam logic [IDX_W-1:0] HALF = IDX_W'(HALF_BITS);

    word_t            sh_q, first_q, sh_nxt;
    logic [IDX_W-1:0] pos;

    assign pos = (idx >= HALF) ? idx - HALF : idx;

    always_comb begin
        if (int'(pos) >= int'(len)) sh_nxt = sh_q;
        else if (pos == '0)         sh_nxt = word_t'(sd_i);
        else                        sh_nxt = {sh_q[MAX_W-2:0], sd_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            first_q <= '0;
        end else if (rise_ev) begin
            sh_q <= sh_nxt;
            if (idx == HALF - 1'b1) first_q <= sh_nxt;
        end
    end

    assign pair_o = en ? pair_t'{first: first_q, second: sh_nxt} : '0;

endmodule

// File: rtl/lj_stereo_port.sv
module lj_stereo_port
    import lj_pkg::*;
#(
    parameter int LANES     = 2,
    parameter int HALF_BITS = 32,
    localparam int IDX_W = $clog2(2*HALF_BITS),
    localparam int PW    = 2*MAX_W,
    localparam int BUS_W = LANES*PW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WL_W-1:0]  cfg_word_len,
    input  logic             cfg_first_fall,
    input  logic [LANES-1:0] tx_lane_en,
    input  logic [LANES-1:0] rx_lane_en,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [BUS_W-1:0] tx_data,
    output logic             tx_underrun,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic [BUS_W-1:0] rx_data,
    output logic             rx_overrun,
    output logic             sck,
    output logic             ws,
    output logic [LANES-1:0] sd_out,
    input  logic [LANES-1:0] sd_in
);
    localparam int LIM = (HALF_BITS < MAX_W) ? HALF_BITS : MAX_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(2*HALF_BITS-1);

    logic             fall_ev, rise_ev, frame_start, pair_done;
    logic [IDX_W-1:0] idx, nxt;
    logic [WL_W-1:0]  len_q, len_use;
    logic [BUS_W-1:0] hold_q, cur_q, src, rx_pack;
    logic             hold_full, under_q, over_q, rxv_q;
    logic [BUS_W-1:0] rxd_q;

    lj_frame_gen #(.HALF_BITS(HALF_BITS)) u_frame (
        .clk(clk), .rst(rst), .cfg_first_fall(cfg_first_fall),
        .sck_o(sck), .ws_o(ws), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .frame_start(frame_start), .idx_o(idx), .nxt_o(nxt)
    );

    assign len_use   = frame_start ? clamp_len(cfg_word_len, LIM) : len_q;
    assign src       = (frame_start && hold_full) ? hold_q : cur_q;
    assign pair_done = rise_ev && (idx == LAST);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pair_t rx_pair;
        lj_tx_lane #(.HALF_BITS(HALF_BITS)) u_tx (
            .clk(clk), .rst(rst), .en(tx_lane_en[l]), .fall_ev(fall_ev),
            .nxt(nxt), .len(len_use), .sample(pair_t'(src[l*PW +: PW])),
            .sd_o(sd_out[l])
        );
        lj_rx_lane #(.HALF_BITS(HALF_BITS)) u_rx (
            .clk(clk), .rst(rst), .en(rx_lane_en[l]), .rise_ev(rise_ev),
            .idx(idx), .len(len_q), .sd_i(sd_in[l]), .pair_o(rx_pair)
        );
        assign rx_pack[l*PW +: PW] = rx_pair;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            cur_q     <= '0;
            len_q     <= WL_W'(MIN_W);
            under_q   <= 1'b0;
            over_q    <= 1'b0;
            rxv_q     <= 1'b0;
            rxd_q     <= '0;
        end else begin
            under_q <= 1'b0;
            over_q  <= 1'b0;
            if (frame_start) begin
                len_q <= len_use;
                if (hold_full) begin
                    cur_q     <= hold_q;
                    hold_full <= 1'b0;
                end else begin
                    under_q <= 1'b1;
                end
            end
            if (tx_valid && !hold_full) begin
                hold_q    <= tx_data;
                hold_full <= 1'b1;
            end
            if (pair_done) begin
                rxd_q <= rx_pack;
                rxv_q <= 1'b1;
                if (rxv_q && !rx_ready) over_q <= 1'b1;
            end else if (rxv_q && rx_ready) begin
                rxv_q <= 1'b0;
            end
        end
    end

    assign tx_ready    = ~hold_full;
    assign tx_underrun = under_q;
    assign rx_overrun  = over_q;
    assign rx_valid    = rxv_q;
    assign rx_data     = rxd_q;

    a_r3_len_range: assert property (@(posedge clk) disable iff (rst)
        (int'(len_q) >= MIN_W) && (int'(len_q) <= LIM));
    a_r7_full_after_accept: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);
    a_r8_underrun_single: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |=> !tx_underrun);
    a_r9_overrun_with_valid: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |-> (rx_valid && $past(rx_valid)));

endmodule

// File: tb/tb_lj_stereo_port.sv
module tb_lj_stereo_port;

    localparam int H  = 32;
    localparam int FP = 4*H;
    localparam int NF = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [5:0]   cfg_word_len = 6'd16;
    logic         cfg_first_fall = 1'b0;
    logic [1:0]   tx_lane_en = 2'b11, rx_lane_en = 2'b11;
    logic         tx_valid = 1'b0, rx_ready = 1'b1;
    logic [127:0] tx_data = '0;
    logic         tx_ready, tx_underrun, rx_valid, rx_overrun, sck, ws;
    logic [127:0] rx_data;
    logic [1:0]   sd_out, sd_in;

    assign sd_in = sd_out;

    lj_stereo_port #(.LANES(2), .HALF_BITS(H)) dut (
        .clk(clk), .rst(rst), .cfg_word_len(cfg_word_len),
        .cfg_first_fall(cfg_first_fall), .tx_lane_en(tx_lane_en),
        .rx_lane_en(rx_lane_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_underrun(tx_underrun), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_overrun(rx_overrun),
        .sck(sck), .ws(ws), .sd_out(sd_out), .sd_in(sd_in)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, frame = 0;
    int f_wl = 16;
    logic f_ff = 1'b0;
    logic [1:0] f_tx = 2'b11, f_rx = 2'b11;
    logic [127:0] cur = '0, held = '0;
    logic held_has = 1'b0, exp_under = 1'b1, stalled = 1'b0, starve = 1'b0;
    logic [31:0] mon = '0;
    logic ws_bad = 1'b0, tail_bad = 1'b0;
    bit done = 1'b0;

    function automatic int clampw(input int v);
        if (v < 8) return 8;
        if (v > 32) return 32;
        return v;
    endfunction

    function automatic logic [31:0] msk(input logic [31:0] w, input int len);
        if (len >= 32) return w;
        return w & ((32'd1 << len) - 32'd1);
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s frame=%0d actual=%h expected=%h", req, frame, act, exp);
        end
    endtask

    task automatic pick_cfg(input int nf);
        int w;
        w = int'($urandom_range(0, 63));
        f_ff = 1'($urandom_range(0, 1));
        f_tx = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b11;
        f_rx = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b11;
        starve  = ($urandom_range(0, 5) == 0);
        stalled = ($urandom_range(0, 5) == 0);
        case (nf)
            1: begin w = 8;  f_ff = 0; f_tx = 2'b11; f_rx = 2'b11; starve = 0; stalled = 0; end
            2: begin w = 32; f_ff = 1; f_tx = 2'b11; f_rx = 2'b11; starve = 0; stalled = 0; end
            3: begin w = 3;  f_ff = 1; starve = 0; stalled = 0; end
            4: begin w = 50; f_ff = 0; starve = 0; stalled = 0; end
            5: begin w = 24; f_tx = 2'b01; f_rx = 2'b11; starve = 1; stalled = 0; end
            6: begin w = 20; f_tx = 2'b11; f_rx = 2'b10; starve = 0; stalled = 1; end
            default: ;
        endcase
        cfg_word_len   = 6'(w);
        f_wl           = clampw(w);
        cfg_first_fall = f_ff;
        tx_lane_en     = f_tx;
        rx_lane_en     = f_rx;
        rx_ready       = ~stalled;
    endtask

    task automatic deliver(input logic was_stalled);
        logic [127:0] exp;
        exp = '0;
        for (int l = 0; l < 2; l++) begin
            if (f_tx[l] && f_rx[l]) begin
                exp[l*64+32 +: 32] = msk(cur[l*64+32 +: 32], f_wl);
                exp[l*64 +: 32]    = msk(cur[l*64 +: 32], f_wl);
            end
        end
        chk("R4/R5/R6 rx_data loopback", rx_data, exp);
        chk("R9 rx_valid at delivery", 128'(rx_valid), 128'(1));
        chk("R9 rx_overrun", 128'(rx_overrun), 128'(was_stalled));
        chk("R2/R3 lane0 first slot MSB-first on wire", 128'(mon),
            128'(f_tx[0] ? msk(cur[63:32], f_wl) : 32'd0));
        chk("R1 ws level per slot", 128'(ws_bad), 128'(0));
        chk("R2 padding bits zero", 128'(tail_bad), 128'(0));
    endtask

    task automatic step();
        logic was;
        tx_valid = 1'b0;
        if (cyc >= 2 && (cyc % 2) == 0) begin
            int i, pos;
            i   = ((cyc - 2) / 2) % (2*H);
            pos = i % H;
            if (ws !== ((i < H) ? ~f_ff : f_ff)) ws_bad = 1'b1;
            if (pos < f_wl) begin
                if (i < H) mon = {mon[30:0], sd_out[0]};
            end else if (sd_out !== 2'b00) begin
                tail_bad = 1'b1;
            end
        end
        if (cyc > 0 && (cyc % FP) == 0) begin
            was = stalled;
            deliver(was);
            frame++;
            mon = '0; ws_bad = 1'b0; tail_bad = 1'b0;
            pick_cfg(frame);
            if (held_has) begin
                cur = held; held_has = 1'b0; exp_under = 1'b0;
            end else begin
                exp_under = 1'b1;
            end
        end
        if ((cyc % FP) == 1)
            chk("R8 underrun pulse at frame start", 128'(tx_underrun), 128'(exp_under));
        if ((cyc % FP) == 3)
            chk("R8 underrun lasts one cycle", 128'(tx_underrun), 128'(0));
        if (!held_has && !starve && tx_ready) begin
            for (int k = 0; k < 4; k++) tx_data[k*32 +: 32] = $urandom();
            tx_valid = 1'b1;
            held     = tx_data;
            held_has = 1'b1;
        end else if ((cyc % FP) == 5 && !held_has) begin
            chk("R7 tx_ready when holding empty", 128'(tx_ready), 128'(1));
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk("R10 reset sd_out", 128'(sd_out), 128'(0));
        chk("R10 reset tx_ready", 128'(tx_ready), 128'(1));
        chk("R10 reset rx_valid", 128'(rx_valid), 128'(0));
        chk("R10 reset pulses", 128'({tx_underrun, rx_overrun}), 128'(0));
        rst = 1'b0;
        while (frame < NF) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2) chk("R1 sck toggles", 128'(sck), 128'(1));
            step();
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired frame=%0d actual=hung expected=finished", frame);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule